// File: doc/BRIEF.md
# Parallel USB FIFO Bridge Controller

This block moves single bytes between on-chip user logic and an external USB bridge device that offers an asynchronous parallel FIFO port. On the device side there is one 8-bit data bus, shared by both directions and split here into an input, an output and an output-enable. There is a read strobe and a write strobe, both active-low, and two active-low status flags. One flag reports that the device's transmit FIFO has room for a byte. The other reports that its receive FIFO holds a byte.

User logic hands over a byte and raises a write request, or it raises a read request and waits for the data-ready indication. Each request acts on its rising edge, so holding a request high never repeats the transfer. A rising edge that arrives while a transfer is in progress is remembered and served later. A request never has to be lowered for the controller to move on.

The device flags are synchronised and then handed to the user as plain status. The user can look at them before issuing a request. A request made while the device cannot serve it stays pending until the flag allows it. All strobe widths, setup and hold times and recovery gaps are whole numbers of clock cycles and are set by parameters.

Top module: `usb_fifo_bridge`

## Requirements
- R1: Each device flag passes through two flip-flops. `tx_space` is the inverse of `dev_room_n` and `rx_avail` is the inverse of `dev_full_n`. A change on a device flag before clock edge k appears on the user flag after edge k+1. Both flip-flops reset to 1, so both user flags read 0 in reset.
- R2: A write is started only by a rising edge of `wr_req`, and only while `tx_space` is 1. The byte on `tx_byte` at that rising edge is the byte written. A request held high produces exactly one write. A request made without room stays pending until room appears.
- R3: A write cycle drives `dev_dq_oe` high with the byte on `dev_dq_o` for 1 cycle before `dev_wstb_n` goes low. It then holds `dev_wstb_n` low for 2 cycles and keeps the byte driven for 1 cycle after the strobe rises. `dev_dq_oe` is low at all other times.
- R4: A rising edge of `rd_req` clears `rx_valid` at that clock edge. The read strobe goes low one clock later, when the device has data, and stays low for 3 cycles. The bus is sampled at the edge that ends the strobe. `rx_byte` takes that value and `rx_valid` returns to 1 at the same edge. A held `rd_req` gives one read.
- R5: When rising edges of `wr_req` and `rd_req` are seen at the same edge, the write strobe happens before the read strobe.
- R6: A rising edge of either request seen while a transfer is running is kept pending and served after the transfer ends. A pending write goes before a pending read.
- R7: A read pending while `rx_avail` is 0 issues no strobe, and `rx_valid` stays 0 until the read completes.
- R8: After any strobe rises, both strobes stay high for at least 2 cycles before either falls again.
- R9: During reset both strobes are high, `dev_dq_oe` is low, `rx_valid` is 0 and `rx_byte` is 0.
- R10: The two strobes are never low together, and the bus is never driven while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_byte | input | 8 | Byte to send, captured on a write request edge |
| wr_req | input | 1 | Write request, acts on rising edge |
| rd_req | input | 1 | Read request, acts on rising edge |
| rx_byte | output | 8 | Last byte read from the device |
| rx_valid | output | 1 | High when rx_byte holds a completed read |
| tx_space | output | 1 | Synchronised: device can accept a byte |
| rx_avail | output | 1 | Synchronised: device holds a byte |
| dev_dq_i | input | 8 | Device data bus, input side |
| dev_dq_o | output | 8 | Device data bus, output side |
| dev_dq_oe | output | 1 | Bus output enable, high only in a write cycle |
| dev_rstb_n | output | 1 | Read strobe, active-low |
| dev_wstb_n | output | 1 | Write strobe, active-low |
| dev_room_n | input | 1 | Device transmit FIFO has room, active-low |
| dev_full_n | input | 1 | Device receive FIFO holds data, active-low |

## Verification
The bench targets these cases:
- A request held high for many cycles. A level-triggered design would write or read the same byte repeatedly.
- Requests raised in the middle of a running transfer. A design that drops them loses the transfer; one that acts on them at once corrupts the strobe sequence.
- Both requests rising together. A wrong design strobes the read first.
- A read or a write issued while the device flag forbids it. A wrong design strobes anyway, or raises `rx_valid` early.
- Every cycle is compared with a behavioural timeline model. Any strobe that is one cycle too short or misplaced is caught. So is a bus enabled outside its write window, or a flag synchroniser of the wrong depth.

// File: rtl/ufb_pkg.sv
package ufb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WLOW,
    ST_WHOLD,
    ST_RLOW,
    ST_REC
  } ufb_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ufb_sync.sv
module ufb_sync #(
  parameter int   W      = 2,
  parameter int   STAGES = 2,
  parameter logic RST_V  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {(STAGES*W){RST_V}};
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ufb_req_edge.sv
module ufb_req_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic take,
  output logic rise,
  output logic pend
);
  logic req_q;

  assign rise = req & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      req_q <= req;
      if (rise)      pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ufb_fsm.sv
module ufb_fsm
  import ufb_pkg::*;
#(
  parameter int DW     = 8,
  parameter int SETUP  = 1,
  parameter int WR_LOW = 2,
  parameter int HOLD   = 1,
  parameter int RD_LOW = 3,
  parameter int RECOV  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tx_byte,
  input  logic          wr_rise,
  input  logic          wr_pend,
  input  logic          rd_rise,
  input  logic          rd_pend,
  input  logic          tx_space,
  input  logic          rx_avail,
  input  logic [DW-1:0] dq_i,
  output logic          wr_take,
  output logic          rd_take,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic          rstb_n,
  output logic          wstb_n
);
  localparam int MAXC = max2(max2(SETUP, WR_LOW), max2(max2(HOLD, RD_LOW), RECOV));
  localparam int CW   = $clog2(MAXC + 1);

  ufb_state_e    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] wbuf;
  logic [DW-1:0] bus_q;
  logic          last;

  assign last    = (cnt == '0);
  assign wr_take = (state == ST_IDLE) && wr_pend && tx_space;
  assign rd_take = (state == ST_IDLE) && !wr_take && rd_pend && rx_avail;

  assign dq_oe  = (state == ST_WSET) || (state == ST_WLOW) || (state == ST_WHOLD);
  assign wstb_n = (state != ST_WLOW);
  assign rstb_n = (state != ST_RLOW);
  assign dq_o   = bus_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      wbuf     <= '0;
      bus_q    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (wr_rise) wbuf <= tx_byte;
      unique case (state)
        ST_IDLE: begin
          if (wr_take) begin
            state <= ST_WSET;
            cnt   <= CW'(SETUP - 1);
            bus_q <= wbuf;
          end else if (rd_take) begin
            state <= ST_RLOW;
            cnt   <= CW'(RD_LOW - 1);
          end
        end
        ST_WSET: begin
          if (last) begin
            state <= ST_WLOW;
            cnt   <= CW'(WR_LOW - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WLOW: begin
          if (last) begin
            state <= ST_WHOLD;
            cnt   <= CW'(HOLD - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WHOLD: begin
          if (last) begin
            state <= ST_REC;
            cnt   <= CW'(RECOV - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_RLOW: begin
          if (last) begin
            state    <= ST_REC;
            cnt      <= CW'(RECOV - 1);
            rx_byte  <= dq_i;
            rx_valid <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        ST_REC: begin
          if (last) state <= ST_IDLE;
          else      cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
      if (rd_rise) rx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_fifo_bridge.sv
module usb_fifo_bridge #(
  parameter int DW     = 8,
  parameter int SYNC   = 2,
  parameter int SETUP  = 1,
  parameter int WR_LOW = 2,
  parameter int HOLD   = 1,
  parameter int RD_LOW = 3,
  parameter int RECOV  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tx_byte,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid,
  output logic          tx_space,
  output logic          rx_avail,
  input  logic [DW-1:0] dev_dq_i,
  output logic [DW-1:0] dev_dq_o,
  output logic          dev_dq_oe,
  output logic          dev_rstb_n,
  output logic          dev_wstb_n,
  input  logic          dev_room_n,
  input  logic          dev_full_n
);
  logic [1:0] flags_s;
  logic       wr_rise, wr_pend, wr_take;
  logic       rd_rise, rd_pend, rd_take;

  ufb_sync #(.W(2), .STAGES(SYNC), .RST_V(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dev_room_n, dev_full_n}), .q(flags_s)
  );

  assign tx_space = ~flags_s[1];
  assign rx_avail = ~flags_s[0];

  ufb_req_edge u_wr_edge (
    .clk(clk), .rst_n(rst_n), .req(wr_req), .take(wr_take),
    .rise(wr_rise), .pend(wr_pend)
  );

  ufb_req_edge u_rd_edge (
    .clk(clk), .rst_n(rst_n), .req(rd_req), .take(rd_take),
    .rise(rd_rise), .pend(rd_pend)
  );

  ufb_fsm #(
    .DW(DW), .SETUP(SETUP), .WR_LOW(WR_LOW), .HOLD(HOLD),
    .RD_LOW(RD_LOW), .RECOV(RECOV)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte),
    .wr_rise(wr_rise), .wr_pend(wr_pend), .rd_rise(rd_rise), .rd_pend(rd_pend),
    .tx_space(tx_space), .rx_avail(rx_avail), .dq_i(dev_dq_i),
    .wr_take(wr_take), .rd_take(rd_take),
    .rx_byte(rx_byte), .rx_valid(rx_valid),
    .dq_o(dev_dq_o), .dq_oe(dev_dq_oe),
    .rstb_n(dev_rstb_n), .wstb_n(dev_wstb_n)
  );
endmodule

// File: rtl/ufb_checker.sv
module ufb_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic [DW-1:0] dev_dq_o,
  input logic          dev_dq_oe,
  input logic          dev_rstb_n,
  input logic          dev_wstb_n
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!dev_rstb_n && !dev_wstb_n)); // R10
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) !dev_rstb_n |-> !dev_dq_oe); // R10
  AST_WSTB_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n) !dev_wstb_n |-> dev_dq_oe); // R3
  AST_W_SETUP: assert property (@(posedge clk) disable iff (!rst_n) $fell(dev_wstb_n) |-> $past(dev_dq_oe)); // R3
  AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(dev_wstb_n) |-> dev_dq_oe); // R3
  AST_W_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(dev_wstb_n) |=> !dev_wstb_n); // R3
  AST_W_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !dev_wstb_n |-> $stable(dev_dq_o)); // R3
  AST_R_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(dev_rstb_n) |=> !dev_rstb_n); // R4
  AST_R_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) !dev_rstb_n |-> !rx_valid); // R4
  AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(rx_valid) |-> $rose(dev_rstb_n)); // R4
  AST_R_RECOVER: assert property (@(posedge clk) disable iff (!rst_n) $rose(dev_rstb_n) |=> (dev_rstb_n && dev_wstb_n)); // R8
  AST_W_RECOVER: assert property (@(posedge clk) disable iff (!rst_n) $rose(dev_wstb_n) |=> (dev_rstb_n && dev_wstb_n)); // R8
endmodule

bind usb_fifo_bridge ufb_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .dev_dq_o(dev_dq_o),
  .dev_dq_oe(dev_dq_oe), .dev_rstb_n(dev_rstb_n), .dev_wstb_n(dev_wstb_n)
);

// File: tb/sim_usb_fifo_bridge.sv
module sim_usb_fifo_bridge;
  localparam int SETUP = 1, WLOW = 2, HOLD = 1, RLOW = 3, RECOV = 2;
  localparam int WLEN = SETUP + WLOW + HOLD + RECOV;
  localparam int RLEN = RLOW + RECOV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] tx_byte = 8'h00, dq_i = 8'h00;
  logic wr_req = 1'b0, rd_req = 1'b0, room_n = 1'b1, full_n = 1'b1;
  logic [7:0] rx_byte, dq_o;
  logic rx_valid, tx_space, rx_avail, dq_oe, rstb_n, wstb_n;

  usb_fifo_bridge #(.SETUP(SETUP), .WR_LOW(WLOW), .HOLD(HOLD), .RD_LOW(RLOW), .RECOV(RECOV)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .wr_req(wr_req), .rd_req(rd_req),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_space(tx_space), .rx_avail(rx_avail),
    .dev_dq_i(dq_i), .dev_dq_o(dq_o), .dev_dq_oe(dq_oe), .dev_rstb_n(rstb_n),
    .dev_wstb_n(wstb_n), .dev_room_n(room_n), .dev_full_n(full_n)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Behavioural timeline model
  bit m_busy, m_wp, m_rp, m_valid, m_r1, m_r2, m_f1, m_f2, m_wprev, m_rprev;
  int m_kind, m_ph;
  logic [7:0] m_wbyte, m_bus, m_rxb;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wp = 0; m_rp = 0; m_valid = 0; m_kind = 0; m_ph = 0;
      m_r1 = 1; m_r2 = 1; m_f1 = 1; m_f2 = 1; m_wprev = 0; m_rprev = 0;
      m_wbyte = 0; m_bus = 0; m_rxb = 0;
    end else begin
      bit space_old, avail_old;
      space_old = !m_r2;
      avail_old = !m_f2;
      if (m_busy) begin
        if (m_kind == 2 && m_ph == RLOW - 1) begin
          m_rxb = dq_i;
          m_valid = 1;
        end
        m_ph++;
        if (m_ph == ((m_kind == 1) ? WLEN : RLEN)) m_busy = 0;
      end else if (m_wp && space_old) begin
        m_busy = 1; m_kind = 1; m_ph = 0; m_bus = m_wbyte; m_wp = 0;
      end else if (m_rp && avail_old) begin
        m_busy = 1; m_kind = 2; m_ph = 0; m_rp = 0;
      end
      if (wr_req && !m_wprev) begin m_wp = 1; m_wbyte = tx_byte; end
      if (rd_req && !m_rprev) begin m_rp = 1; m_valid = 0; end
      m_wprev = wr_req; m_rprev = rd_req;
      m_r2 = m_r1; m_r1 = room_n;
      m_f2 = m_f1; m_f1 = full_n;
    end
  end

  // Per-cycle comparison and device-side monitors
  logic [7:0] got_w[$];
  int ev[$];
  bit p_w = 1, p_r = 1, seen = 0;
  int hi_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_oe, e_w, e_r;
      e_oe = m_busy && m_kind == 1 && m_ph < SETUP + WLOW + HOLD;
      e_w  = !(m_busy && m_kind == 1 && m_ph >= SETUP && m_ph < SETUP + WLOW);
      e_r  = !(m_busy && m_kind == 2 && m_ph < RLOW);
      chk("R3", "dq_oe", {31'd0, dq_oe}, {31'd0, e_oe});
      chk("R3", "wstb_n", {31'd0, wstb_n}, {31'd0, e_w});
      chk("R4", "rstb_n", {31'd0, rstb_n}, {31'd0, e_r});
      if (e_oe) chk("R3", "dq_o", {24'd0, dq_o}, {24'd0, m_bus});
      chk("R4", "rx_valid", {31'd0, rx_valid}, {31'd0, m_valid});
      chk("R4", "rx_byte", {24'd0, rx_byte}, {24'd0, m_rxb});
      chk("R1", "tx_space", {31'd0, tx_space}, {31'd0, !m_r2});
      chk("R1", "rx_avail", {31'd0, rx_avail}, {31'd0, !m_f2});
      chk("R10", "strobes both low", {31'd0, (!rstb_n && !wstb_n)}, 32'd0);
      if (p_w && p_r && (!wstb_n || !rstb_n)) begin
        if (seen) chk("R8", "gap before strobe >= 2", {31'd0, hi_cnt >= RECOV}, 32'd1);
        seen = 1;
      end
      if (wstb_n && rstb_n) hi_cnt++; else hi_cnt = 0;
      if (p_w && !wstb_n) ev.push_back(1);
      if (p_r && !rstb_n) ev.push_back(2);
      if (!p_w && wstb_n) got_w.push_back(dq_o);
      p_w = wstb_n; p_r = rstb_n;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected below 20000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    cycles(3);
    chk("R9", "reset rstb_n", {31'd0, rstb_n}, 32'd1);
    chk("R9", "reset wstb_n", {31'd0, wstb_n}, 32'd1);
    chk("R9", "reset dq_oe", {31'd0, dq_oe}, 32'd0);
    chk("R9", "reset rx_valid", {31'd0, rx_valid}, 32'd0);
    chk("R9", "reset rx_byte", {24'd0, rx_byte}, 32'd0);
    rst_n = 1'b1;
    cycles(2);
    room_n = 1'b0; full_n = 1'b0;
    cycles(3);
    chk("R1", "tx_space after sync", {31'd0, tx_space}, 32'd1);
    chk("R1", "rx_avail after sync", {31'd0, rx_avail}, 32'd1);

    // R2: held write request gives one write
    tx_byte = 8'hA5; wr_req = 1'b1;
    cycles(30);
    chk("R2", "writes for held request", got_w.size(), 1);
    chk("R2", "written byte", {24'd0, got_w[0]}, 32'hA5);
    wr_req = 1'b0; cycles(2);

    // R2: no room keeps write pending, byte captured at edge
    room_n = 1'b1; cycles(4);
    tx_byte = 8'h5A; wr_req = 1'b1; cycles(1);
    wr_req = 1'b0; tx_byte = 8'h00; cycles(20);
    chk("R2", "no write without room", got_w.size(), 1);
    room_n = 1'b0; cycles(20);
    chk("R2", "pending write after room", got_w.size(), 2);
    chk("R2", "pending byte", {24'd0, got_w[1]}, 32'h5A);

    // R4: plain read
    dq_i = 8'h3C; rd_req = 1'b1; cycles(1);
    rd_req = 1'b0; cycles(2);
    chk("R4", "rx_valid low during read", {31'd0, rx_valid}, 32'd0);
    cycles(20);
    chk("R4", "rx_valid after read", {31'd0, rx_valid}, 32'd1);
    chk("R4", "rx_byte after read", {24'd0, rx_byte}, 32'h3C);

    // R7: read with empty device FIFO
    full_n = 1'b1; cycles(4);
    ev.delete();
    dq_i = 8'hC3; rd_req = 1'b1; cycles(1);
    rd_req = 1'b0; cycles(20);
    chk("R7", "no read strobe when empty", ev.size(), 0);
    chk("R7", "rx_valid stays low", {31'd0, rx_valid}, 32'd0);
    full_n = 1'b0; cycles(20);
    chk("R7", "pending read served", {24'd0, rx_byte}, 32'hC3);
    chk("R7", "rx_valid after data", {31'd0, rx_valid}, 32'd1);

    // R5: simultaneous requests
    ev.delete();
    tx_byte = 8'h11; dq_i = 8'h22; wr_req = 1'b1; rd_req = 1'b1; cycles(1);
    wr_req = 1'b0; rd_req = 1'b0; cycles(30);
    chk("R5", "strobe count", ev.size(), 2);
    chk("R5", "write strobe first", ev[0], 1);
    chk("R5", "read second", ev[1], 2);
    chk("R5", "read byte", {24'd0, rx_byte}, 32'h22);

    // R6: requests raised while busy
    ev.delete(); got_w.delete();
    tx_byte = 8'h33; wr_req = 1'b1; cycles(1);
    wr_req = 1'b0; cycles(2);
    tx_byte = 8'h44; dq_i = 8'h55; wr_req = 1'b1; rd_req = 1'b1; cycles(1);
    wr_req = 1'b0; rd_req = 1'b0; cycles(40);
    chk("R6", "strobes served", ev.size(), 3);
    chk("R6", "order W W R", (ev.size() == 3) ? ev[0]*100 + ev[1]*10 + ev[2] : 0, 112);
    chk("R6", "second write byte", (got_w.size() == 2) ? {24'd0, got_w[1]} : 32'hFFFF, 32'h44);
    chk("R6", "read byte", {24'd0, rx_byte}, 32'h55);

    // R4: held read request gives one read
    ev.delete();
    rd_req = 1'b1; cycles(30);
    chk("R4", "reads for held request", ev.size(), 1);
    rd_req = 1'b0; cycles(5);

    done = 1;
    summary();
    $finish;
  end
endmodule